// File: doc/BRIEF.md
# Memory Byte Search Sequencer

This block scans a region of memory for a byte equal to an accumulator value. A start strobe supplies the search value, a 16-bit start address, a 16-bit byte count and the operating mode. On each step the block first decrements the count. It then reads the byte at the current address and compares the search value against it. Finally it moves the address one place up or down. It never writes memory, and it never changes the search value it holds.

The block produces a flag byte in subtract style (search value minus memory byte) together with the count state. Each comparison is judged without producing a difference result. In single-step mode it makes one comparison and finishes. In repeat mode it keeps stepping until the byte matches or the count reaches zero, whichever comes first.

Each step is padded to a fixed number of clock cycles. A repeated search adds an extra tail of cycles before it finishes. Every repeated step raises a one-cycle strobe that tells the surrounding core to sample its interrupt lines. A one-cycle done pulse closes each operation. The final address, count, flags and match result stay on the outputs until the next start.

Top module: `mem_scan_cmp`

## Requirements
- R1: After reset, busy_o, done_o, mem_rd_o and irq_sample_o are 0 and flags_o is 0x00. A start_i seen while idle captures all operands and raises busy_o on the next cycle.
- R2: Each comparison decrements the count by one, modulo 2^16, so 0x0000 becomes 0xFFFF. It compares the captured search value against mem_data_i in the same cycle.
- R3: After each comparison the address becomes address+1 when back_i was 0 at start, or address-1 when back_i was 1, modulo 2^16.
- R4: flags_o uses this bit layout. Bit 7 (sign) is bit 7 of search value minus byte. Bit 6 (zero) is 1 when they are equal. Bit 4 (half) is the borrow out of bit 3, that is 1 when the low nibble of the search value is below the byte's low nibble. Bit 1 (subtract) is always 1. Bits 5 and 3 are 0.
- R5: flags_o bit 2 is 1 when the count after the decrement is nonzero. flags_o bit 0 repeats the carry_i value captured at start.
- R6: mem_rd_o is high for exactly one cycle per comparison. While it is high, mem_addr_o equals the current address. The first address used is ptr_i.
- R7: Single-step mode (rep_i=0) makes one comparison. done_o rises ITER_CYC clock edges after the start edge.
- R8: Repeat mode (rep_i=1) stops after the first comparison where the byte matches or the decremented count is zero. After k comparisons, done_o rises k*ITER_CYC+EXIT_CYC edges after the start edge.
- R9: irq_sample_o pulses once per comparison in repeat mode and never in single-step mode.
- R10: start_i while busy_o is high is ignored. It does not change the result of the operation in progress.
- R11: done_o is high for one cycle, after which busy_o is 0. match_o equals flags_o bit 6, and the results hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, honoured only when idle |
| rep_i | input | 1 | 1 = repeat until match or count zero |
| back_i | input | 1 | 1 = address steps downward |
| acc_i | input | DW | Search value |
| ptr_i | input | AW | Start address |
| cnt_i | input | CW | Byte count |
| carry_i | input | 1 | Carry flag to pass through |
| mem_rd_o | output | 1 | Read strobe, one per comparison |
| mem_addr_o | output | AW | Read address |
| mem_data_i | input | DW | Byte read, valid in the strobe cycle |
| irq_sample_o | output | 1 | Interrupt sample strobe, repeat mode |
| flags_o | output | 8 | Flag byte |
| match_o | output | 1 | Last comparison found equality |
| ptr_o | output | AW | Current address |
| cnt_o | output | CW | Current count |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The two stop conditions of repeat mode can fall on the same step: the matching byte may sit at the last address the count allows. The bench provokes this by planting the search value exactly count-1 places from the start address, and also one place earlier and nowhere. It judges each case by the number of comparisons, the zero and count-nonzero flags, the final address and the completion latency, all computed in the bench. A wide sweep of single-step operations over search value and byte checks the flag arithmetic.

// File: rtl/mem_scan_pkg.sv
package mem_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2,
    ST_DONE = 2'd3
  } scan_state_e;

  localparam int FLG_C  = 0;
  localparam int FLG_N  = 1;
  localparam int FLG_PV = 2;
  localparam int FLG_X  = 3;
  localparam int FLG_H  = 4;
  localparam int FLG_Y  = 5;
  localparam int FLG_Z  = 6;
  localparam int FLG_S  = 7;
endpackage

// File: rtl/mem_scan_flagcalc.sv
module mem_scan_flagcalc
  import mem_scan_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] cnt_next_i,
  input  logic          carry_i,
  output logic [7:0]    flags_o,
  output logic          match_o
);
  logic [DW:0] diff;
  logic [4:0]  nib;

  always_comb begin
    diff    = {1'b0, acc_i} - {1'b0, data_i};
    nib     = {1'b0, acc_i[3:0]} - {1'b0, data_i[3:0]};
    match_o = (diff[DW-1:0] == '0);
    flags_o = '0;
    flags_o[FLG_S]  = diff[DW-1];
    flags_o[FLG_Z]  = match_o;
    flags_o[FLG_H]  = nib[4];
    flags_o[FLG_PV] = (cnt_next_i != '0);
    flags_o[FLG_N]  = 1'b1;
    flags_o[FLG_C]  = carry_i;
  end
endmodule

// File: rtl/mem_scan_pacer.sv
module mem_scan_pacer #(
  parameter int ITER_CYC = 21,
  parameter int EXIT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  input  logic tail_i,
  output logic first_o,
  output logic last_o
);
  localparam int TMAX = (ITER_CYC > EXIT_CYC) ? ITER_CYC : EXIT_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  logic [TW-1:0] wcnt_q, wcnt_d;

  always_comb begin
    first_o = (wcnt_q == '0);
    last_o  = tail_i ? (wcnt_q == TW'(EXIT_CYC - 1))
                     : (wcnt_q == TW'(ITER_CYC - 1));
    wcnt_d  = wcnt_q;
    if (clr_i)       wcnt_d = '0;
    else if (en_i)   wcnt_d = last_o ? '0 : wcnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt_q <= '0;
    else        wcnt_q <= wcnt_d;
  end
endmodule

// File: rtl/mem_scan_fsm.sv
module mem_scan_fsm
  import mem_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        rep_i,
  input  logic        stop_i,
  input  logic        last_i,
  output scan_state_e state_o
);
  scan_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN: begin
        if (last_i) begin
          if (!rep_i)      state_d = ST_DONE;
          else if (stop_i) state_d = ST_TAIL;
        end
      end
      ST_TAIL: if (last_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mem_scan_cmp.sv
module mem_scan_cmp
  import mem_scan_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CW       = 16,
  parameter int DW       = 8,
  parameter int ITER_CYC = 21,
  parameter int EXIT_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          rep_i,
  input  logic          back_i,
  input  logic [DW-1:0] acc_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          carry_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_data_i,
  output logic          irq_sample_o,
  output logic [7:0]    flags_o,
  output logic          match_o,
  output logic [AW-1:0] ptr_o,
  output logic [CW-1:0] cnt_o,
  output logic          busy_o,
  output logic          done_o
);
  // reset: asserted at once, released on the clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  scan_state_e   state;
  logic          first, last, stop_w, stop_q;
  logic          load_en, cmp_en;
  logic [DW-1:0] acc_q;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [CW-1:0] cnt_q, cnt_dec;
  logic          rep_q, back_q, carry_q, match_q, match_w;
  logic [7:0]    flags_q, flags_w;

  mem_scan_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .rep_i   (rep_q),
    .stop_i  (stop_w),
    .last_i  (last),
    .state_o (state)
  );

  mem_scan_pacer #(.ITER_CYC(ITER_CYC), .EXIT_CYC(EXIT_CYC)) u_pacer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (state == ST_IDLE),
    .en_i    ((state == ST_RUN) || (state == ST_TAIL)),
    .tail_i  (state == ST_TAIL),
    .first_o (first),
    .last_o  (last)
  );

  mem_scan_flagcalc #(.DW(DW), .CW(CW)) u_flag (
    .acc_i      (acc_q),
    .data_i     (mem_data_i),
    .cnt_next_i (cnt_dec),
    .carry_i    (carry_q),
    .flags_o    (flags_w),
    .match_o    (match_w)
  );

  always_comb begin
    load_en = (state == ST_IDLE) && start_i;
    cmp_en  = (state == ST_RUN) && first;
    cnt_dec = cnt_q - CW'(1);
    ptr_d   = back_q ? (ptr_q - AW'(1)) : (ptr_q + AW'(1));
    stop_w  = cmp_en ? ((cnt_dec == '0) || match_w) : stop_q;
  end

  // operand capture
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q   <= '0;
      rep_q   <= 1'b0;
      back_q  <= 1'b0;
      carry_q <= 1'b0;
    end else if (load_en) begin
      acc_q   <= acc_i;
      rep_q   <= rep_i;
      back_q  <= back_i;
      carry_q <= carry_i;
    end
  end

  // walking address and count
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (load_en) begin
      ptr_q <= ptr_i;
      cnt_q <= cnt_i;
    end else if (cmp_en) begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_dec;
    end
  end

  // comparison results
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flags_q <= '0;
      match_q <= 1'b0;
      stop_q  <= 1'b0;
    end else if (cmp_en) begin
      flags_q <= flags_w;
      match_q <= match_w;
      stop_q  <= stop_w;
    end
  end

  assign mem_rd_o     = cmp_en;
  assign mem_addr_o   = ptr_q;
  assign irq_sample_o = cmp_en && rep_q;
  assign flags_o      = flags_q;
  assign match_o      = match_q;
  assign ptr_o        = ptr_q;
  assign cnt_o        = cnt_q;
  assign busy_o       = (state != ST_IDLE);
  assign done_o       = (state == ST_DONE);
endmodule

// File: rtl/mem_scan_chk.sv
module mem_scan_chk #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_rd_o,
  input logic          irq_sample_o,
  input logic          match_o,
  input logic [7:0]    flags_o,
  input logic [AW-1:0] ptr_o,
  input logic [CW-1:0] cnt_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          rep_q,
  input logic          back_q,
  input logic [DW-1:0] acc_q
);
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> cnt_o == $past(cnt_o) - CW'(1));

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> ptr_o == (back_q ? $past(ptr_o) - AW'(1) : $past(ptr_o) + AW'(1)));

  assert_sub_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flags_o[1] && !flags_o[5] && !flags_o[3]));

  assert_pv_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> flags_o[2] == (cnt_o != '0));

  assert_read_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> (busy_o && mem_addr_o == ptr_o));

  assert_read_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o);

  assert_repeat_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && rep_q && !match_o) |-> cnt_o == '0);

  assert_irq_repeat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sample_o |-> (mem_rd_o && rep_q));

  assert_no_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && !rep_q) |-> !irq_sample_o);

  assert_hold_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(acc_q));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  assert_match_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> match_o == flags_o[6]);
endmodule

bind mem_scan_cmp mem_scan_chk #(.AW(AW), .CW(CW), .DW(DW)) u_chk (.*);

// File: tb/sim_mem_scan_cmp.sv
`timescale 1ns/1ps
module sim_mem_scan_cmp;
  localparam int ITER = 3;
  localparam int EXIT = 2;

  logic        clk, rst_n;
  logic        start_i, rep_i, back_i, carry_i;
  logic [7:0]  acc_i;
  logic [15:0] ptr_i, cnt_i;
  logic        mem_rd_o, irq_sample_o, match_o, busy_o, done_o;
  logic [15:0] mem_addr_o, ptr_o, cnt_o;
  logic [7:0]  mem_data_i, flags_o;

  int errors = 0;
  int checks = 0;

  // memory model controls
  bit          fixed_mode;
  logic [7:0]  fixed_byte;
  bit          plant_en;
  logic [15:0] plant_addr;
  logic [7:0]  cur_acc;

  mem_scan_cmp #(.ITER_CYC(ITER), .EXIT_CYC(EXIT)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rep_i(rep_i),
    .back_i(back_i), .acc_i(acc_i), .ptr_i(ptr_i), .cnt_i(cnt_i),
    .carry_i(carry_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_data_i(mem_data_i), .irq_sample_o(irq_sample_o), .flags_o(flags_o),
    .match_o(match_o), .ptr_o(ptr_o), .cnt_o(cnt_o), .busy_o(busy_o),
    .done_o(done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] byte_at(input logic [15:0] a);
    if (fixed_mode) return fixed_byte;
    if (plant_en && a == plant_addr) return cur_acc;
    return cur_acc ^ {1'b1, a[6:0]};
  endfunction

  always_comb mem_data_i = byte_at(mem_addr_o);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run(input bit rep, input bit back, input logic [7:0] acc,
                     input logic [15:0] ptr, input logic [15:0] cnt,
                     input bit cin, input bit inject);
    logic [15:0] p, c, ea;
    logic [7:0]  m, ef;
    int k, lat, nrd, nirq;
    bit addr_ok;
    // model
    p = ptr; c = cnt; k = 0; m = '0;
    cur_acc = acc;
    while (1) begin
      c = c - 16'd1;
      m = byte_at(p);
      k++;
      p = back ? p - 16'd1 : p + 16'd1;
      if (!rep) break;
      if (c == 16'd0 || m == acc) break;
    end
    ef = {((acc - m) & 8'h80) != 0 ? 1'b1 : 1'b0, acc == m, 1'b0,
          (acc & 8'h0f) < (m & 8'h0f), 1'b0, c != 16'd0, 1'b1, cin};
    // drive
    @(negedge clk);
    start_i = 1'b1; rep_i = rep; back_i = back; acc_i = acc;
    ptr_i = ptr; cnt_i = cnt; carry_i = cin;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0; acc_i = ~acc; ptr_i = ~ptr; cnt_i = 16'h5555;
    rep_i = ~rep; back_i = ~back; carry_i = ~cin;
    lat = 0; nrd = 0; nirq = 0; addr_ok = 1'b1; ea = ptr;
    while (!done_o && lat < 5000) begin
      start_i = inject && (lat == 1);
      if (mem_rd_o) begin
        if (mem_addr_o != ea) addr_ok = 1'b0;
        ea = back ? ea - 16'd1 : ea + 16'd1;
        nrd++;
      end
      if (irq_sample_o) nirq++;
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    start_i = 1'b0;
    if (rep) chk(lat == k*ITER + EXIT, "R8 latency", lat, k*ITER + EXIT);
    else     chk(lat == ITER, "R7 latency", lat, ITER);
    chk(flags_o == ef, "R4/R5 flags", flags_o, ef);
    chk(match_o == ef[6], "R11 match", match_o, ef[6]);
    chk(ptr_o == p, "R3 pointer", ptr_o, p);
    chk(cnt_o == c, "R2 count", cnt_o, c);
    chk(nrd == k && addr_ok, "R6 reads", nrd, k);
    chk(nirq == (rep ? k : 0), "R9 irq strobes", nirq, rep ? k : 0);
    @(negedge clk);
    chk(!busy_o && !done_o, "R11 done pulse", {busy_o, done_o}, 0);
    if (inject) chk(!busy_o, "R10 start ignored while busy", busy_o, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    start_i = 0; rep_i = 0; back_i = 0; acc_i = 0; ptr_i = 0; cnt_i = 0;
    carry_i = 0; fixed_mode = 0; fixed_byte = 0; plant_en = 0;
    plant_addr = 0; cur_acc = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !mem_rd_o && !irq_sample_o, "R1 reset idle",
        {busy_o, done_o, mem_rd_o, irq_sample_o}, 0);
    chk(flags_o == 8'h00, "R1 reset flags", flags_o, 0);
    // R1 start raises busy
    @(negedge clk);
    fixed_mode = 1; fixed_byte = 8'h10; cur_acc = 8'h10;
    start_i = 1; rep_i = 0; back_i = 0; acc_i = 8'h10; ptr_i = 16'h0100;
    cnt_i = 16'd2; carry_i = 0;
    @(negedge clk);
    start_i = 0;
    chk(busy_o, "R1 busy after start", busy_o, 1);
    while (busy_o) @(negedge clk);

    // R4/R5/R7 single-step sweep over search value and byte
    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 256; b++) begin
        fixed_byte = 8'(b);
        run(1'b0, 1'(b & 1), 8'(a), 16'(a * 257 + b), 16'(b & 3), 1'(a & 1), 1'b0);
      end
    end
    // R2 count wrap in single step
    fixed_byte = 8'h33;
    run(1'b0, 1'b0, 8'h33, 16'h2000, 16'h0000, 1'b1, 1'b0);
    fixed_mode = 0;

    // R8 repeat: match before count runs out
    plant_en = 1; plant_addr = 16'h1004;
    run(1'b1, 1'b0, 8'h5a, 16'h1000, 16'd10, 1'b0, 1'b0);
    // R8 match and count exhaustion on the same step
    plant_addr = 16'h1002;
    run(1'b1, 1'b0, 8'hc3, 16'h1000, 16'd3, 1'b1, 1'b0);
    // R8 match one step before exhaustion
    plant_addr = 16'h1001;
    run(1'b1, 1'b0, 8'h07, 16'h1000, 16'd3, 1'b0, 1'b0);
    // R8 match on the first byte, backward
    plant_addr = 16'h3000;
    run(1'b1, 1'b1, 8'h80, 16'h3000, 16'd8, 1'b0, 1'b0);
    // R3 backward with match deep in
    plant_addr = 16'h2ffb;
    run(1'b1, 1'b1, 8'h21, 16'h3000, 16'd20, 1'b1, 1'b0);
    plant_en = 0;
    // R8 no match, count runs out, backward
    run(1'b1, 1'b1, 8'h44, 16'h4000, 16'd6, 1'b0, 1'b0);
    // R3 forward pointer wrap
    run(1'b1, 1'b0, 8'h99, 16'hfffe, 16'd4, 1'b1, 1'b0);
    // R3 backward pointer wrap
    run(1'b1, 1'b1, 8'h12, 16'h0001, 16'd3, 1'b0, 1'b0);
    // R8 count of one
    run(1'b1, 1'b0, 8'hff, 16'h7777, 16'd1, 1'b1, 1'b0);
    // R10 start pulses during busy operations
    run(1'b1, 1'b0, 8'h66, 16'h5000, 16'd5, 1'b0, 1'b1);
    fixed_mode = 1; fixed_byte = 8'h01;
    run(1'b0, 1'b1, 8'h00, 16'h0000, 16'd1, 1'b1, 1'b1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule